// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Error Status

This block takes an asynchronous serial line and turns each frame on it into a byte. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth (parity) bit, and a high stop bit. The block needs an external tick at sixteen times the bit rate. It confirms the start bit at its middle, samples every later bit at its middle, and places the finished byte in a receive buffer. A ready flag tells the host that a new byte is waiting.

Three status bits report faults. The overwrite flag means a byte arrived before the host took the previous one. The frame flag means the last stop bit was sampled low. The break flag means the line had stayed low for longer than ten and a half bit times when the last frame ended. The host clears the ready flag with either a buffer read strobe or a dedicated clear strobe. It clears the overwrite flag by writing 0 to it through a one-bit status write port.

The frame sequencer has five states. IDLE goes to START on a tick that sees the line low. START goes back to IDLE (false start) or forward to DATA on its eighth tick, depending on the line level at that tick. DATA stays in DATA until the eighth bit is taken, then goes to NINTH when the ninth bit is enabled and to STOP otherwise. NINTH goes to STOP after one bit time. STOP goes to IDLE when the stop bit is sampled, and that is the cycle in which the frame completes.

Top module: `srx_top`

## Requirements
- R1: While reset is held and after it is released, the buffer, the ready flag and all three error flags read 0, and the receiver waits for a start bit.
- R2: The line passes through two flip-flops before any use. A tick that sees the synchronized line low starts a frame. On the 8th tick after that one the line is sampled again: a high level abandons the frame (nothing is loaded and no flag changes), and a low level confirms the start.
- R3: After a confirmed start, each data bit is sampled every 16 ticks, least significant bit first. The byte is written into the buffer only in the clock cycle in which the stop bit is sampled, and the buffer holds that byte until the next frame completes.
- R4: When ninth_en is 1, one extra bit is sampled 16 ticks after the 8th data bit and then discarded, and the stop bit follows 16 ticks later. When ninth_en is 0, the stop bit follows the 8th data bit directly.
- R5: The ready flag becomes 1 in the completion cycle. It returns to 0 on buf_rd or rdy_clr. If completion and a clear fall in the same cycle, completion wins.
- R6: When a frame completes while the ready flag is 1, ovr_err becomes 1 and the buffer takes the new byte.
- R7: ovr_err stays at 1 until a status write (ovr_wr_en = 1) with ovr_wr_data = 0. A write of 1 leaves it unchanged. A new overwrite in the same cycle as a clearing write keeps it at 1.
- R8: frm_err is rewritten at the end of every frame: 1 when the stop bit was sampled low, and 0 when it was sampled high.
- R9: brk_err is rewritten at the end of every frame. It is 1 when the synchronized line had been low on every tick of a run of more than 168 ticks (10.5 bit times) that ends at the stop-bit sample, and 0 otherwise. The threshold is the same whatever ninth_en is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| ninth_en | input | 1 | 1 adds a ninth bit to the frame |
| buf_rd | input | 1 | Buffer read strobe, clears ready |
| rdy_clr | input | 1 | Ready flag clear strobe |
| ovr_wr_en | input | 1 | Status write strobe for the overwrite flag |
| ovr_wr_data | input | 1 | Value written; 0 clears the overwrite flag |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | A new byte is waiting |
| ovr_err | output | 1 | Overwrite error |
| frm_err | output | 1 | Framing error of the last frame |
| brk_err | output | 1 | Line break seen at the end of the last frame |

## Verification
The bench attacks the places where the break threshold and the frame length interact. Holding the line low with nine-bit frames has to raise the break flag on the very first frame. With eight-bit frames, the first all-low frame ends after only 9.5 bit times and must not show a break, while the frame that starts right after it must show one. A design that shortened the threshold along with the frame would flag the first frame. A design that did not count across frames would never flag the second.

A short low glitch must leave the buffer and the flags untouched. A sequencer that skipped the start confirmation would load a spurious byte of ones. Overwrite, and the rule that a write of 1 leaves the overwrite flag as it is, are checked against a behavioural model on every clock. That catches a flag that clears on any write or that forgets to replace the byte. A frame with a low stop bit followed by a good frame shows whether the frame flag is really rewritten on every frame or left sticky.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int OSR  = 16;
    localparam int HALF = OSR / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_lowrun.sv
module srx_lowrun #(
    parameter int LIMIT = 168,
    localparam int CW   = $clog2(LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    output logic brk_hit
);
    localparam logic [CW-1:0] MAXC = '1;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (line)                 run_cnt <= '0;
            else if (run_cnt != MAXC) run_cnt <= run_cnt + 1'b1;
        end
    end

    // run long enough and line still low on this tick
    assign brk_hit = !line && (run_cnt >= CW'(LIMIT));

    // a high line on a tick ends any run
    assert_run_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && line) |=> !brk_hit);
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW),
    localparam int CNTW = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic          ninth_en,
    output logic          done,
    output logic [DW-1:0] byte_o,
    output logic          stop_o
);
    srx_state_e      state, nstate;
    logic [CNTW-1:0] cnt;
    logic [BW-1:0]   bit_idx;
    logic [DW-1:0]   shreg;
    logic            smp, half;

    assign smp  = tick && (cnt == CNTW'(OSR - 1));
    assign half = tick && (cnt == CNTW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:  if (tick && !line) nstate = ST_START;
            ST_START: if (half) nstate = line ? ST_IDLE : ST_DATA;
            ST_DATA:  if (smp && bit_idx == BW'(DW - 1))
                          nstate = ninth_en ? ST_NINTH : ST_STOP;
            ST_NINTH: if (smp) nstate = ST_STOP;
            ST_STOP:  if (smp) begin
                          nstate = ST_IDLE;
                          done   = 1'b1;
                      end
            default:  nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else if (tick) begin
            if (state == ST_IDLE || nstate != state || smp) cnt <= '0;
            else                                            cnt <= cnt + 1'b1;
            if (state == ST_START) bit_idx <= '0;
            if (state == ST_DATA && smp) begin
                shreg   <= {line, shreg[DW-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign byte_o = shreg;
    assign stop_o = line;

    // without a tick the sequencer never moves
    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));
endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int BRK_TICKS  = (DW + 2) * OSR + HALF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_in,
    input  logic          os_tick,
    input  logic          ninth_en,
    input  logic          buf_rd,
    input  logic          rdy_clr,
    input  logic          ovr_wr_en,
    input  logic          ovr_wr_data,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          brk_err
);
    logic          line_s;
    logic          brk_hit;
    logic          frame_done;
    logic [DW-1:0] frame_byte;
    logic          stop_bit;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd_in), .dout(line_s)
    );

    srx_lowrun #(.LIMIT(BRK_TICKS)) u_lowrun (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .brk_hit(brk_hit)
    );

    srx_frame_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
        .ninth_en(ninth_en), .done(frame_done), .byte_o(frame_byte), .stop_o(stop_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
            ovr_err  <= 1'b0;
            frm_err  <= 1'b0;
            brk_err  <= 1'b0;
        end else if (frame_done) begin
            rx_data  <= frame_byte;
            rx_ready <= 1'b1;
            ovr_err  <= ovr_err | rx_ready;
            frm_err  <= ~stop_bit;
            brk_err  <= brk_hit;
        end else begin
            if (buf_rd || rdy_clr)         rx_ready <= 1'b0;
            if (ovr_wr_en && !ovr_wr_data) ovr_err  <= 1'b0;
        end
    end

    assert_ready_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_ready);
    assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_ready) |=> ovr_err);
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !(ovr_wr_en && !ovr_wr_data)) |=> ovr_err);
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_data));
    assert_frm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(frm_err));
    assert_brk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(brk_err));
endmodule

// File: tb/tb_srx_top.sv
module tb_srx_top;
    localparam int TP  = 4;
    localparam int BIT = 16 * TP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_in = 1'b1;
    logic       os_tick = 1'b0;
    logic       ninth_en = 1'b0;
    logic       buf_rd = 1'b0;
    logic       rdy_clr = 1'b0;
    logic       ovr_wr_en = 1'b0;
    logic       ovr_wr_data = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, ovr_err, frm_err, brk_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    srx_top dut (
        .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .os_tick(os_tick),
        .ninth_en(ninth_en), .buf_rd(buf_rd), .rdy_clr(rdy_clr),
        .ovr_wr_en(ovr_wr_en), .ovr_wr_data(ovr_wr_data),
        .rx_data(rx_data), .rx_ready(rx_ready), .ovr_err(ovr_err),
        .frm_err(frm_err), .brk_err(brk_err)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (TP - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic       m_s1, m_s2;
    int         m_ph, m_low;
    logic [7:0] m_sh, m_data;
    logic       m_rdy, m_ovr, m_frm, m_brk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_ph = -1; m_low = 0; m_sh = 0;
            m_data = 0; m_rdy = 0; m_ovr = 0; m_frm = 0; m_brk = 0;
        end else begin
            logic lin;
            bit   fin, brk_now;
            int   p, k;
            lin = m_s2; fin = 0; brk_now = 0;
            if (os_tick) begin
                brk_now = !lin && (m_low >= 168);
                m_low = lin ? 0 : m_low + 1;
                if (m_ph < 0) begin
                    if (!lin) m_ph = 0;
                end else begin
                    p = m_ph + 1;
                    m_ph = p;
                    if (p == 8) begin
                        if (lin) m_ph = -1;
                    end else if (p > 8 && (p - 8) % 16 == 0) begin
                        k = (p - 8) / 16;
                        if (k <= 8) m_sh[k-1] = lin;
                        if (k == (ninth_en ? 10 : 9)) begin
                            fin = 1;
                            m_ph = -1;
                        end
                    end
                end
            end
            if (fin) begin
                m_ovr = m_ovr | m_rdy;
                m_rdy = 1; m_data = m_sh; m_frm = !lin; m_brk = brk_now;
            end else begin
                if (rdy_clr || buf_rd) m_rdy = 0;
                if (ovr_wr_en && !ovr_wr_data) m_ovr = 0;
            end
            m_s2 = m_s1;
            m_s1 = rxd_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 data vs model", rx_data, m_data);
            chk("R5 ready vs model", rx_ready, m_rdy);
            chk("R6 overwrite vs model", ovr_err, m_ovr);
            chk("R8 frame error vs model", frm_err, m_frm);
            chk("R9 break vs model", brk_err, m_brk);
        end
    end

    task automatic send_frame(input logic [7:0] b, input logic nb, input logic sb);
        rxd_in = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_in = b[i];
            repeat (BIT) @(negedge clk);
        end
        if (ninth_en) begin
            rxd_in = nb;
            repeat (BIT) @(negedge clk);
        end
        rxd_in = sb;
        repeat (BIT) @(negedge clk);
        rxd_in = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!rx_ready) @(negedge clk);
    endtask

    task automatic pulse_clr();
        rdy_clr = 1'b1;
        @(negedge clk);
        rdy_clr = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset data", rx_data, 0);
        chk("R1 reset flags", {rx_ready, ovr_err, frm_err, brk_err}, 0);
        rst_n = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        chk("R1 idle after reset", {rx_ready, ovr_err, frm_err, brk_err}, 0);

        send_frame(8'hA5, 1'b0, 1'b1);
        chk("R3 byte A5", rx_data, 8'hA5);
        chk("R5 ready set", rx_ready, 1);
        chk("R8 good stop", frm_err, 0);
        buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
        chk("R5 read clears ready", rx_ready, 0);

        ninth_en = 1'b1;
        send_frame(8'h3C, 1'b1, 1'b1);
        chk("R4 ninth bit frame", rx_data, 8'h3C);
        chk("R6 no overwrite yet", ovr_err, 0);
        send_frame(8'h81, 1'b0, 1'b1);
        chk("R6 overwrite set", ovr_err, 1);
        chk("R6 byte replaced", rx_data, 8'h81);
        ovr_wr_en = 1'b1; ovr_wr_data = 1'b1; @(negedge clk); ovr_wr_en = 1'b0;
        chk("R7 write one keeps flag", ovr_err, 1);
        ovr_wr_en = 1'b1; ovr_wr_data = 1'b0; @(negedge clk); ovr_wr_en = 1'b0;
        chk("R7 write zero clears", ovr_err, 0);
        pulse_clr();
        chk("R5 clear strobe", rx_ready, 0);

        rxd_in = 1'b0; repeat (3 * TP) @(negedge clk); rxd_in = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        chk("R2 glitch no load", rx_ready, 0);
        chk("R2 glitch keeps buffer", rx_data, 8'h81);

        ninth_en = 1'b0;
        send_frame(8'h55, 1'b0, 1'b0);
        chk("R8 low stop flagged", frm_err, 1);
        chk("R3 byte 55", rx_data, 8'h55);
        pulse_clr();
        send_frame(8'h0F, 1'b0, 1'b1);
        chk("R8 flag rewritten", frm_err, 0);
        pulse_clr();

        ninth_en = 1'b1;
        rxd_in = 1'b0;
        wait_ready();
        chk("R9 break with ninth bit", brk_err, 1);
        chk("R8 break frame stop low", frm_err, 1);
        chk("R3 break byte", rx_data, 0);
        pulse_clr();
        repeat (12 * BIT) @(negedge clk);
        rxd_in = 1'b1;
        repeat (16 * BIT) @(negedge clk);
        pulse_clr();
        send_frame(8'hC3, 1'b0, 1'b1);
        chk("R9 break cleared by good frame", brk_err, 0);
        pulse_clr();

        ninth_en = 1'b0;
        rxd_in = 1'b0;
        wait_ready();
        chk("R9 short frame no break", brk_err, 0);
        pulse_clr();
        wait_ready();
        chk("R9 second frame break", brk_err, 1);
        rxd_in = 1'b1;
        repeat (16 * BIT) @(negedge clk);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule